// File: doc/BRIEF.md
# Single-Wire Memory Read Command Processor

This block sits behind a byte-level single-wire slave: the bit engine hands it each byte the host writes and asks it for each byte the host reads. It decodes the first-level commands (identity read, select) and the second-level read commands. It then streams bytes from three sources: a 64-bit identity word, a 128-byte data field arranged as four 32-byte pages, and an 8-byte status area. A CRC-8 travels with the data.

Every transaction starts with a bus reset. The host either reads the identity word directly, or selects the function level and issues a plain read, a paged read, a status read or a profile query. The data field and status area are read through address/data ports that it shares with the programming sequencer. The data ports are combinational: the data input must reflect the address output in the same cycle.

Top module: `mem_read_cmd`

## Requirements
- R1: After a bus reset, command 33h makes the next eight reads return `id_word` least significant byte first (bits 7:0 first, bits 63:56 last). Every read after that returns FFh.
- R2: Only 33h or CCh is accepted as the first byte after a bus reset. Any other first byte, including a valid second-level code, makes every read return FFh until the next bus reset, and later bytes are ignored.
- R3: After CCh, the second-level codes F0h, C3h and AAh take an address low byte and then a high byte. The first read then returns the CRC-8 of those three bytes. The CRC uses x^8+x^5+x^4+1, data shifted in least significant bit first (reflected constant 8Ch), starting from 00h.
- R4: Under F0h, reads return data bytes from the start address up to address 127, then one CRC over all data bytes read (restarted from 00h), then FFh.
- R5: Under C3h, reads return data bytes up to the end of the current 32-byte page, then a CRC over that page's bytes. The CRC restarts from 00h for the next page. After the CRC of page 3 (addresses 96..127), reads return FFh.
- R6: Under AAh, reads return status bytes from the start address (0..7) up to byte 7, then a CRC over those bytes, then FFh.
- R7: After CCh, code 99h makes the next read return 55h, and later reads return FFh.
- R8: After CCh, any code other than F0h, C3h, AAh or 99h makes every read return FFh until the next bus reset.
- R9: A start address outside its area (high byte nonzero, or low byte above 127 for data or above 7 for status) gives the header CRC, then a CRC of 00h, then FFh.
- R10: `tx_valid` is high exactly in the cycle after `tx_req`, with `tx_byte` holding the reply. Bytes written by the host during the read phase are ignored.
- R11: `bus_reset` aborts any command at once. No reply is flagged in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Pulse: reset/presence sequence seen on the wire |
| rx_valid | input | 1 | Host-written byte available |
| rx_byte | input | 8 | Byte written by the host |
| tx_req | input | 1 | Bit engine requests the next byte for the host |
| tx_valid | output | 1 | Reply byte valid |
| tx_byte | output | 8 | Reply byte |
| id_word | input | 64 | Identity word: family code, serial number, stored CRC |
| mem_addr | output | 7 | Data field read address |
| mem_data | input | 8 | Data field byte at `mem_addr` |
| stat_addr | output | 3 | Status area read address |
| stat_data | input | 8 | Status byte at `stat_addr` |

## Verification
The hardest cases to reach are the transitions out of a page-end CRC in paged mode. These are the restart of the CRC, the step to the next page, and the switch to all-ones after page 3. They only happen after a long run of reads from a valid start. The bench drives whole transactions from a table of commands and start addresses, one of them just before a page end. For each it computes the full expected byte stream, header CRC and trailing FFh included, from its own memory model.

// File: rtl/mem_read_cmd.sv
module mem_read_cmd #(
  parameter int DW        = 8,
  parameter int MEM_BYTES = 128,
  parameter int PAGE      = 32,
  parameter int STAT      = 8,
  parameter int ID_BYTES  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_reset,
  input  logic                         rx_valid,
  input  logic [DW-1:0]                rx_byte,
  input  logic                         tx_req,
  output logic                         tx_valid,
  output logic [DW-1:0]                tx_byte,
  input  logic [ID_BYTES*DW-1:0]       id_word,
  output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
  input  logic [DW-1:0]                mem_data,
  output logic [$clog2(STAT)-1:0]      stat_addr,
  input  logic [DW-1:0]                stat_data
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE);
  localparam int SW = $clog2(STAT);
  localparam int IW = $clog2(ID_BYTES);

  typedef enum logic [3:0] {
    S_ROM, S_FUNC, S_ALO, S_AHI, S_HDR, S_DATA, S_DCRC, S_IDRD, S_PROF, S_DONE, S_IDLE
  } st_t;
  typedef enum logic [1:0] {M_FLD, M_PAGE, M_STAT} md_t;

  st_t            st;
  md_t            md;
  logic [DW-1:0]  crc, alo, ahi;
  logic [AW-1:0]  ptr;
  logic [IW-1:0]  icnt;
  logic           fin;

  function automatic logic [DW-1:0] crc8(input logic [DW-1:0] c, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = c;
    for (int i = 0; i < DW; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign mem_addr  = ptr;
  assign stat_addr = ptr[SW-1:0];

  wire [DW-1:0] dbyte  = (md == M_STAT) ? stat_data : mem_data;
  wire          oor    = (ahi != '0) ||
                         ((md == M_STAT) ? (alo >= DW'(STAT)) : (alo >= DW'(MEM_BYTES)));
  wire          at_end = (md == M_STAT) ? (ptr[SW-1:0] == SW'(STAT-1)) :
                         (md == M_PAGE) ? (ptr[PW-1:0] == PW'(PAGE-1)) :
                                          (ptr == AW'(MEM_BYTES-1));
  wire          last   = (md == M_STAT) ? (ptr[SW-1:0] == SW'(STAT-1)) :
                                          (ptr == AW'(MEM_BYTES-1));

  logic [DW-1:0] out_byte;
  always_comb begin
    case (st)
      S_HDR, S_DCRC: out_byte = crc;
      S_DATA:        out_byte = dbyte;
      S_IDRD:        out_byte = id_word[icnt*DW +: DW];
      S_PROF:        out_byte = 8'h55;
      default:       out_byte = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '1;
    end else begin
      tx_valid <= tx_req && !bus_reset;
      if (tx_req && !bus_reset) tx_byte <= out_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= M_FLD; crc <= '0; alo <= '0; ahi <= '0;
      ptr <= '0; icnt <= '0; fin <= 1'b0;
    end else if (bus_reset) begin
      st <= S_ROM; crc <= '0; icnt <= '0; fin <= 1'b0; ptr <= '0;
    end else begin
      case (st)
        S_ROM: if (rx_valid) begin
          if (rx_byte == 8'h33)      st <= S_IDRD;
          else if (rx_byte == 8'hCC) st <= S_FUNC;
          else                       st <= S_IDLE;
        end
        S_FUNC: if (rx_valid) begin
          crc <= crc8('0, rx_byte);
          case (rx_byte)
            8'hF0:   begin md <= M_FLD;  st <= S_ALO; end
            8'hC3:   begin md <= M_PAGE; st <= S_ALO; end
            8'hAA:   begin md <= M_STAT; st <= S_ALO; end
            8'h99:   st <= S_PROF;
            default: st <= S_IDLE;
          endcase
        end
        S_ALO: if (rx_valid) begin
          alo <= rx_byte; crc <= crc8(crc, rx_byte); st <= S_AHI;
        end
        S_AHI: if (rx_valid) begin
          ahi <= rx_byte; crc <= crc8(crc, rx_byte); st <= S_HDR;
          ptr <= alo[AW-1:0];
        end
        S_HDR: if (tx_req) begin
          crc <= '0;
          fin <= oor;
          st  <= oor ? S_DCRC : S_DATA;
        end
        S_DATA: if (tx_req) begin
          crc <= crc8(crc, dbyte);
          ptr <= ptr + 1'b1;
          if (at_end) begin
            st  <= S_DCRC;
            fin <= last;
          end
        end
        S_DCRC: if (tx_req) begin
          crc <= '0;
          st  <= fin ? S_DONE : S_DATA;
        end
        S_IDRD: if (tx_req) begin
          icnt <= icnt + 1'b1;
          if (icnt == IW'(ID_BYTES-1)) st <= S_DONE;
        end
        S_PROF: if (tx_req) st <= S_DONE;
        default: ;
      endcase
    end
  end
endmodule

module mem_read_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       tx_req,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic [6:0] mem_addr
);
  logic armed, dead;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; dead <= 1'b0;
    end else if (bus_reset) begin
      armed <= 1'b1; dead <= 1'b0;
    end else if (armed && rx_valid) begin
      armed <= 1'b0;
      dead  <= (rx_byte != 8'h33) && (rx_byte != 8'hCC);
    end
  end

  p_reply_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !bus_reset) |=> tx_valid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> !tx_valid);
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !tx_valid);
  p_reject_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && tx_req && !bus_reset) |=> (tx_byte == 8'hFF));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && !rx_valid && !bus_reset) |=> $stable(mem_addr));
endmodule

bind mem_read_cmd mem_read_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .mem_addr(mem_addr)
);

// File: tb/sim_mem_read_cmd.sv
module sim_mem_read_cmd;
  logic        clk = 0, rst_n = 0, bus_reset = 0, rx_valid = 0, tx_req = 0;
  logic [7:0]  rx_byte = 0;
  logic        tx_valid;
  logic [7:0]  tx_byte, mem_data, stat_data;
  logic [6:0]  mem_addr;
  logic [2:0]  stat_addr;
  logic [63:0] id_word = 64'hA7_12_34_56_78_9A_BC_09;

  always #5 clk = ~clk;

  assign mem_data  = 8'(mem_addr * 37 + 8'h5A);
  assign stat_data = (stat_addr == 3'd7) ? 8'h00 : 8'(8'hC1 + stat_addr * 3);

  mem_read_cmd u0 (.clk, .rst_n, .bus_reset, .rx_valid, .rx_byte, .tx_req,
    .tx_valid, .tx_byte, .id_word, .mem_addr, .mem_data, .stat_addr, .stat_data);

  int checks = 0, fails = 0;
  logic [7:0] expv [0:159];
  int nexp;

  localparam logic [23:0] VEC [0:8] = '{
    24'hF0_00_00, 24'hF0_7C_00, 24'hC3_3E_00, 24'hC3_00_00, 24'hAA_00_00,
    24'hAA_05_00, 24'hF0_00_01, 24'hAA_08_00, 24'hC3_80_00 };

  function automatic logic [7:0] c8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = {1'b0, r[7:1]};
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  function automatic logic [7:0] mref(input int a); return 8'(a * 37 + 8'h5A); endfunction
  function automatic logic [7:0] sref(input int a); return (a == 7) ? 8'h00 : 8'(8'hC1 + a * 3); endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, ex);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rd(output logic [7:0] b, output logic v);
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0; b = tx_byte; v = tx_valid;
  endtask

  task automatic breset;
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic build(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi);
    logic [7:0] c;
    int a;
    nexp = 0;
    c = c8(c8(c8(8'h00, cmd), lo), hi);
    expv[nexp++] = c;
    c = 0;
    if (cmd == 8'hAA) begin
      if (hi == 0 && lo < 8) for (a = lo; a < 8; a++) begin expv[nexp++] = sref(a); c = c8(c, sref(a)); end
      expv[nexp++] = c;
    end else if (hi != 0 || lo > 127) begin
      expv[nexp++] = 8'h00;
    end else begin
      for (a = lo; a < 128; a++) begin
        expv[nexp++] = mref(a); c = c8(c, mref(a));
        if (cmd == 8'hC3 && (a % 32) == 31) begin expv[nexp++] = c; c = 0; end
      end
      if (cmd == 8'hF0) expv[nexp++] = c;
    end
    expv[nexp++] = 8'hFF;
    expv[nexp++] = 8'hFF;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] b; logic v;
    string tag;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {7'd0, tx_valid}, 8'h00);
    rst_n = 1;
    rd(b, v);
    chk("R2 read before any bus reset", b, 8'hFF);

    foreach (VEC[k]) begin
      logic [7:0] cmd = VEC[k][23:16];
      breset; wr(8'hCC); wr(cmd); wr(VEC[k][15:8]); wr(VEC[k][7:0]);
      build(cmd, VEC[k][15:8], VEC[k][7:0]);
      tag = (VEC[k][7:0] != 0 || (cmd == 8'hAA && VEC[k][15:8] > 7) || VEC[k][15:8] > 127) ? "R9" :
            (cmd == 8'hF0) ? "R4" : (cmd == 8'hC3) ? "R5" : "R6";
      for (int i = 0; i < nexp; i++) begin
        rd(b, v);
        if (i == 0) chk("R3 header crc", b, expv[i]);
        else chk(tag, b, expv[i]);
        if (i == 1) chk("R10 valid flag", {7'd0, v}, 8'h01);
        if (i == 2) wr(8'h00);
      end
    end

    breset; wr(8'h33);
    for (int i = 0; i < 8; i++) begin rd(b, v); chk("R1 id byte", b, id_word[i*8 +: 8]); end
    rd(b, v); chk("R1 after id", b, 8'hFF);

    breset; wr(8'hCC); wr(8'h99);
    rd(b, v); chk("R7 profile", b, 8'h55);
    rd(b, v); chk("R7 after profile", b, 8'hFF);

    breset; wr(8'hF0); wr(8'hCC); wr(8'h33);
    rd(b, v); chk("R2 rejected without select", b, 8'hFF);

    breset; wr(8'hCC); wr(8'h42); wr(8'hF0); wr(8'h00); wr(8'h00);
    rd(b, v); chk("R8 unknown code", b, 8'hFF);

    breset; wr(8'hCC); wr(8'hF0); wr(8'h10); wr(8'h00);
    rd(b, v); rd(b, v); chk("R4 first data", b, mref(16));
    @(negedge clk); bus_reset = 1; tx_req = 1;
    @(negedge clk); bus_reset = 0; tx_req = 0;
    chk("R11 no reply after bus reset", {7'd0, tx_valid}, 8'h00);
    wr(8'h33); rd(b, v); chk("R11 fresh command after abort", b, id_word[7:0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule